// File: doc/BRIEF.md
# Flash Status Register Protection Logic

This block holds the two 8-bit status registers of a serial NOR flash slave and decides whether a status-register write may change them. An upstream command decoder hands it a one-cycle write strobe with two data bytes, one for each register. It also supplies one-cycle suspend and resume strobes and the level of the active-low write-protect pin. The block returns both register values, a one-cycle acknowledge for each honoured write, a quad-enable level for the pad multiplexers, and one lock flag for each of the three security registers.

Two resets drive the block. `por_ni` models a full power cycle and clears every bit. `rst_ni` is a soft reset. It clears only the acknowledge flop, so the bits treated as nonvolatile keep their values through it, and so does the suspend flag.

Top module: `sreg_guard`

## Requirements
- R1: While `por_ni` is low, both registers read 0x00 and `wr_ok_o`, `qe_o` and `lock_o` are 0.
- R2: Taking `rst_ni` low leaves both register values and the suspend flag unchanged, and forces `wr_ok_o` to 0.
- R3: An honoured write loads all eight bits of register 1 from `wr_sr1_i`. In register 2 it loads bit 0 (SRP1), bit 1 (QE) and bit 6 (CMP) from `wr_sr2_i`. Register 2 bit 2 always reads 0.
- R4: A write is refused, leaving both registers unchanged and `wr_ok_o` low, when all of these hold: `wp_ni` is 0, register 1 bit 7 (SRP0) is 1, register 2 bit 0 (SRP1) is 0, and register 2 bit 1 (QE) is 0.
- R5: While QE is 1, the level of `wp_ni` has no effect on whether a write is honoured.
- R6: While SRP1 is 1 or SRP0 is 0, writes are honoured whatever the level of `wp_ni`.
- R7: Register 2 bits 3, 4 and 5 are lock bits for security registers 1, 2 and 3. An honoured write can set a lock bit but can never clear it. `lock_o[n-1]` equals register 2 bit 2+n.
- R8: Register 2 bit 7 (SUS) ignores write data.
- R9: `susp_i` sets SUS and `resm_i` clears it. If both strobes are high in the same cycle, SUS becomes 1. `por_ni` clears SUS.
- R10: `wr_ok_o` is high for exactly the cycle after each honoured write, and low after a refused write or an idle cycle.
- R11: `qe_o` follows register 2 bit 1 and changes only in the cycle after an honoured write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Soft reset, active low, asynchronous |
| por_ni | input | 1 | Power-cycle reset, active low, asynchronous |
| wr_i | input | 1 | Decoded write-status strobe |
| wr_sr1_i | input | 8 | Data for register 1 |
| wr_sr2_i | input | 8 | Data for register 2 |
| wp_ni | input | 1 | Write-protect pin level |
| susp_i | input | 1 | Decoded suspend strobe (command 0x75) |
| resm_i | input | 1 | Decoded resume strobe (command 0x7A) |
| sr1_o | output | 8 | Register 1 value |
| sr2_o | output | 8 | Register 2 value |
| wr_ok_o | output | 1 | Write-honoured pulse |
| qe_o | output | 1 | Quad-enable level |
| lock_o | output | 3 | Security register lock flags |

## Verification
The hardest state to reach is the hardware-locked one, because the write that sets SRP0 must itself be honoured. The stimulus therefore first sets SRP0 with the pin high, then drops the pin. It also passes through SRP1 set to 1 and through QE set to 1, so the same low pin level is seen both refusing and honouring writes. After the locks are set, the bench writes zeros to the lock bits and to SUS, raises suspend and resume in the same cycle, and brackets everything with a soft reset and a power cycle.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  localparam int SR_W     = 8;
  localparam int SRP0_BIT = 7;  // register 1
  localparam int SRP1_BIT = 0;  // register 2
  localparam int QE_BIT   = 1;
  localparam int RSV_BIT  = 2;
  localparam int LB_LSB   = 3;
  localparam int NUM_LB   = 3;
  localparam int CMP_BIT  = 6;
  localparam int SUS_BIT  = 7;
  localparam logic [SR_W-1:0] SR2_RW_MASK =
    SR_W'((1 << SRP1_BIT) | (1 << QE_BIT) | (1 << CMP_BIT));
endpackage

// File: rtl/sreg_gate.sv
module sreg_gate (
  input  logic wr_i,
  input  logic wp_ni,
  input  logic srp0_i,
  input  logic srp1_i,
  input  logic qe_i,
  output logic accept_o
);
  logic hw_lock;
  // pin only protects when quad mode has not taken it over as IO2
  assign hw_lock  = !wp_ni && srp0_i && !srp1_i && !qe_i;
  assign accept_o = wr_i && !hw_lock;
endmodule

// File: rtl/sreg_nv.sv
module sreg_nv
  import sreg_pkg::*;
(
  input  logic            clk_i,
  input  logic            por_ni,
  input  logic            accept_i,
  input  logic [SR_W-1:0] d1_i,
  input  logic [SR_W-1:0] d2_i,
  output logic [SR_W-1:0] sr1_o,
  output logic [SR_W-1:0] sr2_nv_o,
  output logic [NUM_LB-1:0] lb_o
);
  logic [SR_W-1:0] sr1_q, sr2_rw_q;

  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni) begin
      sr1_q    <= '0;
      sr2_rw_q <= '0;
    end else if (accept_i) begin
      sr1_q    <= d1_i;
      sr2_rw_q <= d2_i & SR2_RW_MASK;
    end
  end

  // one-time-settable lock bits
  for (genvar n = 0; n < NUM_LB; n++) begin : g_lb
    logic lb_q;
    always_ff @(posedge clk_i or negedge por_ni) begin
      if (!por_ni)                         lb_q <= 1'b0;
      else if (accept_i && d2_i[LB_LSB+n]) lb_q <= 1'b1;
    end
    assign lb_o[n] = lb_q;
  end

  always_comb begin
    sr2_nv_o = sr2_rw_q;
    sr2_nv_o[LB_LSB +: NUM_LB] = lb_o;
  end
  assign sr1_o = sr1_q;
endmodule

// File: rtl/sreg_sus.sv
module sreg_sus (
  input  logic clk_i,
  input  logic por_ni,
  input  logic susp_i,
  input  logic resm_i,
  output logic sus_o
);
  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni)     sus_o <= 1'b0;
    else if (susp_i) sus_o <= 1'b1;  // suspend wins a tie
    else if (resm_i) sus_o <= 1'b0;
  end
endmodule

// File: rtl/sreg_guard.sv
module sreg_guard
  import sreg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              por_ni,
  input  logic              wr_i,
  input  logic [SR_W-1:0]   wr_sr1_i,
  input  logic [SR_W-1:0]   wr_sr2_i,
  input  logic              wp_ni,
  input  logic              susp_i,
  input  logic              resm_i,
  output logic [SR_W-1:0]   sr1_o,
  output logic [SR_W-1:0]   sr2_o,
  output logic              wr_ok_o,
  output logic              qe_o,
  output logic [NUM_LB-1:0] lock_o
);
  logic            accept, sus;
  logic [SR_W-1:0] sr2_nv;

  sreg_gate u_gate (
    .wr_i    (wr_i),
    .wp_ni   (wp_ni),
    .srp0_i  (sr1_o[SRP0_BIT]),
    .srp1_i  (sr2_nv[SRP1_BIT]),
    .qe_i    (sr2_nv[QE_BIT]),
    .accept_o(accept)
  );

  sreg_nv u_nv (
    .clk_i   (clk_i),
    .por_ni  (por_ni),
    .accept_i(accept),
    .d1_i    (wr_sr1_i),
    .d2_i    (wr_sr2_i),
    .sr1_o   (sr1_o),
    .sr2_nv_o(sr2_nv),
    .lb_o    (lock_o)
  );

  sreg_sus u_sus (
    .clk_i (clk_i),
    .por_ni(por_ni),
    .susp_i(susp_i),
    .resm_i(resm_i),
    .sus_o (sus)
  );

  always_ff @(posedge clk_i or negedge por_ni or negedge rst_ni) begin
    if (!por_ni || !rst_ni) wr_ok_o <= 1'b0;
    else                    wr_ok_o <= accept;
  end

  always_comb begin
    sr2_o          = sr2_nv;
    sr2_o[SUS_BIT] = sus;
  end
  assign qe_o = sr2_nv[QE_BIT];
endmodule

// File: rtl/sreg_guard_chk.sv
module sreg_guard_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       por_ni,
  input logic       wr_i,
  input logic       wp_ni,
  input logic       susp_i,
  input logic       resm_i,
  input logic [7:0] sr1_o,
  input logic [7:0] sr2_o,
  input logic       wr_ok_o,
  input logic       qe_o,
  input logic [2:0] lock_o
);
  p_blocked_hold_r4: assert property (@(posedge clk_i) disable iff (!por_ni || !rst_ni)
    (wr_i && !wp_ni && sr1_o[7] && !sr2_o[0] && !sr2_o[1])
      |=> ($stable(sr1_o) && $stable(sr2_o[6:0]) && !wr_ok_o));

  p_lock_sticky_r7: assert property (@(posedge clk_i) disable iff (!por_ni)
    (lock_o != 3'b000) |=> ((lock_o & $past(lock_o)) == $past(lock_o)));

  p_sus_set_r9: assert property (@(posedge clk_i) disable iff (!por_ni)
    susp_i |=> sr2_o[7]);

  p_sus_clr_r9: assert property (@(posedge clk_i) disable iff (!por_ni)
    (resm_i && !susp_i) |=> !sr2_o[7]);

  p_sus_ro_r8: assert property (@(posedge clk_i) disable iff (!por_ni)
    (!susp_i && !resm_i) |=> $stable(sr2_o[7]));

  p_no_ack_r10: assert property (@(posedge clk_i) disable iff (!por_ni || !rst_ni)
    !wr_i |=> !wr_ok_o);

  p_qe_change_r11: assert property (@(posedge clk_i) disable iff (!por_ni || !rst_ni)
    !$stable(qe_o) |-> wr_ok_o);
endmodule

bind sreg_guard sreg_guard_chk u_chk (.*);

// File: tb/sreg_guard_tb_top.sv
module sreg_guard_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b1, por_ni = 1'b0;
  logic       wr_i = 1'b0, wp_ni = 1'b1, susp_i = 1'b0, resm_i = 1'b0;
  logic [7:0] wr_sr1_i = '0, wr_sr2_i = '0;
  logic [7:0] sr1_o, sr2_o;
  logic       wr_ok_o, qe_o;
  logic [2:0] lock_o;

  int checks = 0, errors = 0;
  logic [7:0] m1 = '0, m2 = '0;

  typedef struct {
    logic [7:0] s1, s2;
    logic       ack;
    string      tag;
  } exp_t;
  exp_t q[$];

  always #2 clk_i = ~clk_i;

  sreg_guard dut_i (.*);

  task automatic cmp(input string tag, input logic [7:0] s1, input logic [7:0] s2, input logic ack);
    checks++;
    if (sr1_o !== s1 || sr2_o !== s2 || wr_ok_o !== ack ||
        qe_o !== s2[1] || lock_o !== s2[5:3]) begin
      errors++;
      $display("FAIL %s: sr1=%h sr2=%h ack=%b qe=%b lock=%b exp sr1=%h sr2=%h ack=%b qe=%b lock=%b",
               tag, sr1_o, sr2_o, wr_ok_o, qe_o, lock_o, s1, s2, ack, s2[1], s2[5:3]);
    end
  endtask

  // driver: one operation per cycle, expected result into the scoreboard
  task automatic op(input logic wr, input logic [7:0] d1, input logic [7:0] d2,
                    input logic wp, input logic sp, input logic rs, input string tag);
    logic blk, acc;
    exp_t e;
    @(negedge clk_i);
    wr_i = wr; wr_sr1_i = d1; wr_sr2_i = d2; wp_ni = wp; susp_i = sp; resm_i = rs;
    blk = !wp && m1[7] && !m2[0] && !m2[1];
    acc = wr && !blk;
    if (acc) begin
      m1 = d1;
      m2[0] = d2[0]; m2[1] = d2[1]; m2[6] = d2[6];
      m2[5:3] = m2[5:3] | d2[5:3];
    end
    if (sp) m2[7] = 1'b1;
    else if (rs) m2[7] = 1'b0;
    e.s1 = m1; e.s2 = m2; e.ack = acc; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor
  initial forever begin
    @(posedge clk_i);
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      cmp(e.tag, e.s1, e.s2, e.ack);
    end
  end

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: run hung, actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #9;
    cmp("R1 reset", 8'h00, 8'h00, 1'b0);
    @(negedge clk_i); por_ni = 1'b1;
    op(1, 8'h3C, 8'h88, 1, 0, 0, "R3 R7 R8 first write");
    op(0, 8'h00, 8'h00, 1, 0, 0, "R10 idle");
    op(1, 8'h80, 8'h00, 1, 0, 0, "R7 lock sticky");
    op(1, 8'h11, 8'h30, 0, 0, 0, "R4 pin blocks");
    op(1, 8'h81, 8'h01, 1, 0, 0, "R6 set SRP1");
    op(1, 8'h80, 8'h11, 0, 0, 0, "R6 SRP1 overrides pin");
    op(1, 8'h80, 8'h00, 0, 0, 0, "R6 clear SRP1");
    op(1, 8'h80, 8'h02, 0, 0, 0, "R4 blocked again");
    op(1, 8'h80, 8'h02, 1, 0, 0, "R11 QE on");
    op(1, 8'h85, 8'h62, 0, 0, 0, "R5 QE ignores pin");
    op(0, 8'h00, 8'h00, 0, 1, 0, "R9 suspend");
    op(1, 8'h85, 8'h00, 1, 0, 0, "R8 R7 R11 zeros written");
    op(0, 8'h00, 8'h00, 1, 0, 1, "R9 resume");
    op(0, 8'h00, 8'h00, 1, 1, 1, "R9 tie suspend wins");
    op(1, 8'h85, 8'h80, 1, 0, 0, "R10 write before soft reset");
    @(negedge clk_i);
    wr_i = 0; susp_i = 0; resm_i = 0;
    wait (q.size() == 0);
    @(negedge clk_i); rst_ni = 1'b0;
    #1;
    cmp("R2 soft reset keeps", m1, m2, 1'b0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    cmp("R2 after soft reset", m1, m2, 1'b0);
    op(0, 8'h00, 8'h00, 1, 1, 0, "R9 suspend before power cycle");
    @(negedge clk_i); susp_i = 0;
    wait (q.size() == 0);
    @(negedge clk_i); por_ni = 1'b0;
    #1;
    m1 = '0; m2 = '0;
    cmp("R1 R9 power cycle clears", 8'h00, 8'h00, 1'b0);
    @(negedge clk_i); por_ni = 1'b1;
    op(1, 8'hA5, 8'h38, 1, 0, 0, "R7 locks after power cycle");
    @(negedge clk_i); wr_i = 0;
    wait (q.size() == 0);
    @(negedge clk_i);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule